// File: doc/BRIEF.md
# Interrupt Cause Collector with Assertion Throttling

This block gathers event bits from the receive and transmit engines into a sticky cause register. It compares them with a programmable enable mask and drives a single level-sensitive interrupt line to the host. A programmable throttle interval keeps a minimum spacing between line assertions, so a burst of completions yields one interrupt and not one interrupt per event. A request marked urgent bypasses the throttle. The block also runs four delay timers that convert packet completions into receive-timer and transmit-done causes. Two of them are per-packet and restart on every packet. The other two are absolute and cap the total wait.

The host programs the mask, the throttle interval and the four delay values through a simple write strobe with a select code. It services the interrupt by reading the cause register. The read returns the accumulated bits and clears them, which also releases the line. All times are counted in cycles of the block clock. The throttle counts in units of `THR_UNIT_CYC` cycles and the delay timers in units of `DLY_TICK_CYC` cycles.

Top module: `irq_throttle_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `irq_o` is 0 and `cause_q` is all zero. All timers are idle.
- R2: A cause bit set by a pulse or by an internal event stays set until the cause register is read. `cause_q[CAUSE_W-1:0]` holds the cause bits. `cause_q[CAUSE_W]` is the asserted flag, which is set whenever the line is raised, and `irq_o` equals that flag.
- R3: With a throttle interval of zero, a new cause that survives the mask raises `irq_o` on the clock edge that samples the pulse.
- R4: The throttle interval is written with select code 1. With a nonzero interval N, a new non-urgent cause starts the throttle timer only if the timer is idle. The timer posts N*THR_UNIT_CYC cycles after the sampling edge. Rewriting the interval does not change a timer that is already running.
- R5: A pulse with `cause_now` high posts on the next edge whatever the interval is, and cancels any running throttle timer.
- R6: A non-urgent pulse whose bits are all already pending has no effect at all. In particular, it does not start the throttle timer.
- R7: Posting is suppressed when no pending cause bit is enabled in the mask.
- R8: The mask is written with select code 0 and re-evaluates the line at once. If no pending cause survives the new mask, `irq_o` drops and the throttle timer is cancelled. Otherwise the block posts at once when the interval is zero, or starts the throttle timer if it is idle.
- R9: A pulse on `icr_rd` clears all cause bits and the flag at that edge, and `irq_o` drops. Causes arriving in the same cycle are kept.
- R10: When a post succeeds while the receive per-packet timer is running, cause bit `RXT_BIT` (7) is set and that timer is cancelled.
- R11: The receive per-packet delay (select 2) and the transmit per-packet delay (select 4) restart on every `rx_pkt_done` or `tx_pkt_done` pulse and expire after value*DLY_TICK_CYC cycles. On expiry they raise bit 7 (receive timer) or bit `TXDW_BIT` (0, transmit done), respectively. A zero delay raises that bit at once on completion.
- R12: The receive absolute delay (select 3) and the transmit absolute delay (select 5) start on a packet completion only when both that direction's absolute value and its per-packet value are nonzero, and only when the timer is idle. On expiry after value*DLY_TICK_CYC cycles they raise the same bit as their per-packet partner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cause_pulse | input | CAUSE_W | One-cycle cause event bits |
| cause_now | input | 1 | Marks the cause pulse of this cycle as urgent |
| rx_pkt_done | input | 1 | A receive packet completed |
| tx_pkt_done | input | 1 | A transmit packet completed |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 mask, 1 throttle, 2..5 delay values |
| wr_data | input | VAL_W | Write data (the mask uses the low CAUSE_W bits) |
| icr_rd | input | 1 | Read-and-clear of the cause register |
| irq_o | output | 1 | Level interrupt to the host |
| cause_q | output | CAUSE_W+1 | Cause register readback, with the asserted flag in the MSB |

## Verification
The hardest case to reach is proving that an ignored event did not quietly arm a timer, because a timer that is running cannot be seen at the ports. The stimulus sets this up deliberately. It arranges a pending cause with the line dropped by a mask write, then pulses the same cause again, and then re-enables the mask a few cycles later. Because a running throttle timer is never restarted, a wrongly armed timer would fire early, so the exact cycle of the rise shows whether the timer was armed. The same technique checks that urgent posts and folded receive timers really cancel their counters: a fresh event is timed after the cancel.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Register select codes seen on wr_sel
    typedef enum logic [2:0] {
        SEL_MASK     = 3'd0,
        SEL_THROTTLE = 3'd1,
        SEL_RX_PKT   = 3'd2,
        SEL_RX_ABS   = 3'd3,
        SEL_TX_PKT   = 3'd4,
        SEL_TX_ABS   = 3'd5
    } reg_sel_e;

    // Delay timer slots; slot g is written with select SEL_DLY_BASE + g
    localparam int TMR_RX_PKT   = 0;
    localparam int TMR_RX_ABS   = 1;
    localparam int TMR_TX_PKT   = 2;
    localparam int TMR_TX_ABS   = 3;
    localparam int NUM_DLY_TMR  = 4;
    localparam int SEL_DLY_BASE = 2;

    // Throttle decisions taken in one cycle
    typedef struct packed {
        logic post_req;
        logic start_thr;
        logic cancel_thr;
        logic drop_line;
    } thr_ctl_t;

    function automatic logic [2:0] dly_sel(input int idx);
        return 3'(SEL_DLY_BASE + idx);
    endfunction

endpackage

// File: rtl/irq_timer.sv
module irq_timer #(
    parameter int VAL_W = 16,
    parameter int SCALE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VAL_W-1:0] val_i,
    input  logic             start_i,   // load only when idle
    input  logic             reload_i,  // load unconditionally
    input  logic             cancel_i,
    output logic             busy_o,
    output logic             expire_o
);
    localparam int CNT_W = VAL_W + $clog2(SCALE + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_v;

    assign load_v   = CNT_W'(val_i) * CNT_W'(SCALE);
    assign busy_o   = (cnt_q != '0);
    // Driven from the counter only, so a cancel never loops back into it
    assign expire_o = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cancel_i) begin
            cnt_q <= '0;
        end else if (reload_i || (start_i && !busy_o)) begin
            cnt_q <= load_v;
        end else if (busy_o) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/irq_cause_core.sv
module irq_cause_core
    import irq_pkg::*;
#(
    parameter int CAUSE_W = 8,
    parameter int RXT_BIT = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CAUSE_W-1:0] ext_cause,
    input  logic               ext_now,
    input  logic [CAUSE_W-1:0] int_cause,
    input  logic               icr_rd,
    input  logic               mask_wr,
    input  logic [CAUSE_W-1:0] mask_wdata,
    input  logic               thr_zero,
    input  logic               thr_expire,
    input  logic               rxpkt_busy,
    output logic               start_thr,
    output logic               cancel_thr,
    output logic               cancel_rxpkt,
    output logic [CAUSE_W-1:0] add_vec,
    output logic [CAUSE_W-1:0] mask_q,
    output logic [CAUSE_W:0]   cause_q,
    output logic               irq_o
);
    localparam logic [CAUSE_W-1:0] RXT_MASK = CAUSE_W'(1) << RXT_BIT;

    logic [CAUSE_W-1:0] bits_q, bits_d;
    logic               flag_q, flag_d;
    logic [CAUSE_W-1:0] base_v, merged_v, mask_nxt;
    logic               live, fresh, urgent_in, act, urgent, post_ok;
    thr_ctl_t           ctl;

    always_comb begin
        add_vec   = ext_cause | int_cause;
        base_v    = icr_rd ? '0 : bits_q;
        merged_v  = base_v | add_vec;
        mask_nxt  = mask_wr ? mask_wdata : mask_q;
        live      = |(merged_v & mask_nxt);
        fresh     = |(add_vec & ~base_v);
        urgent_in = ext_now && (|ext_cause);
        act       = (|add_vec) && (fresh || urgent_in);
        urgent    = act && (thr_zero || urgent_in);

        ctl.post_req   = thr_expire || urgent || (mask_wr && live && thr_zero);
        ctl.start_thr  = (act && !urgent) || (mask_wr && live && !thr_zero);
        ctl.drop_line  = mask_wr && !live;
        post_ok        = ctl.post_req && live;
        ctl.cancel_thr = post_ok || urgent || ctl.drop_line;

        cancel_rxpkt = post_ok && rxpkt_busy;
        bits_d       = merged_v | (cancel_rxpkt ? RXT_MASK : '0);

        if (post_ok)
            flag_d = 1'b1;
        else if (ctl.drop_line || icr_rd)
            flag_d = 1'b0;
        else
            flag_d = flag_q;

        start_thr  = ctl.start_thr;
        cancel_thr = ctl.cancel_thr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            flag_q <= 1'b0;
            mask_q <= '0;
        end else begin
            bits_q <= bits_d;
            flag_q <= flag_d;
            if (mask_wr)
                mask_q <= mask_wdata;
        end
    end

    assign cause_q = {flag_q, bits_q};
    assign irq_o   = flag_q;

endmodule

// File: rtl/irq_throttle_ctrl.sv
module irq_throttle_ctrl
    import irq_pkg::*;
#(
    parameter int CAUSE_W      = 8,
    parameter int VAL_W        = 16,
    parameter int THR_UNIT_CYC = 4,
    parameter int DLY_TICK_CYC = 2,
    parameter int RXT_BIT      = 7,
    parameter int TXDW_BIT     = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CAUSE_W-1:0] cause_pulse,
    input  logic               cause_now,
    input  logic               rx_pkt_done,
    input  logic               tx_pkt_done,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [VAL_W-1:0]   wr_data,
    input  logic               icr_rd,
    output logic               irq_o,
    output logic [CAUSE_W:0]   cause_q
);
    localparam logic [CAUSE_W-1:0] RXT_MASK  = CAUSE_W'(1) << RXT_BIT;
    localparam logic [CAUSE_W-1:0] TXDW_MASK = CAUSE_W'(1) << TXDW_BIT;

    logic [VAL_W-1:0]       thr_val;
    logic [VAL_W-1:0]       dly_val [NUM_DLY_TMR];
    logic [NUM_DLY_TMR-1:0] dly_start, dly_reload, dly_cancel, dly_busy, dly_exp;
    logic                   thr_start, thr_cancel, thr_busy, thr_exp;
    logic                   cancel_rxpkt, rx_time, tx_time;
    logic [CAUSE_W-1:0]     int_cause, core_add, core_mask;
    logic                   mask_wr;

    assign mask_wr = wr_en && (wr_sel == SEL_MASK);

    // Programmable values
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_val <= '0;
            for (int i = 0; i < NUM_DLY_TMR; i++)
                dly_val[i] <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_THROTTLE)
                thr_val <= wr_data;
            for (int i = 0; i < NUM_DLY_TMR; i++)
                if (wr_sel == dly_sel(i))
                    dly_val[i] <= wr_data;
        end
    end

    // Packet completions drive the delay timers
    always_comb begin
        dly_start  = '0;
        dly_reload = '0;
        dly_cancel = '0;
        dly_reload[TMR_RX_PKT] = rx_pkt_done;
        dly_reload[TMR_TX_PKT] = tx_pkt_done;
        dly_start[TMR_RX_ABS]  = rx_pkt_done && (dly_val[TMR_RX_PKT] != '0)
                                 && (dly_val[TMR_RX_ABS] != '0);
        dly_start[TMR_TX_ABS]  = tx_pkt_done && (dly_val[TMR_TX_PKT] != '0)
                                 && (dly_val[TMR_TX_ABS] != '0);
        dly_cancel[TMR_RX_PKT] = cancel_rxpkt;

        rx_time = dly_exp[TMR_RX_PKT] || dly_exp[TMR_RX_ABS] ||
                  (rx_pkt_done && (dly_val[TMR_RX_PKT] == '0));
        tx_time = dly_exp[TMR_TX_PKT] || dly_exp[TMR_TX_ABS] ||
                  (tx_pkt_done && (dly_val[TMR_TX_PKT] == '0));
        int_cause = (rx_time ? RXT_MASK : '0) | (tx_time ? TXDW_MASK : '0);
    end

    for (genvar g = 0; g < NUM_DLY_TMR; g++) begin : g_dly
        irq_timer #(
            .VAL_W (VAL_W),
            .SCALE (DLY_TICK_CYC)
        ) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .val_i    (dly_val[g]),
            .start_i  (dly_start[g]),
            .reload_i (dly_reload[g]),
            .cancel_i (dly_cancel[g]),
            .busy_o   (dly_busy[g]),
            .expire_o (dly_exp[g])
        );
    end

    irq_timer #(
        .VAL_W (VAL_W),
        .SCALE (THR_UNIT_CYC)
    ) u_thr (
        .clk      (clk),
        .rst      (rst),
        .val_i    (thr_val),
        .start_i  (thr_start),
        .reload_i (1'b0),
        .cancel_i (thr_cancel),
        .busy_o   (thr_busy),
        .expire_o (thr_exp)
    );

    irq_cause_core #(
        .CAUSE_W (CAUSE_W),
        .RXT_BIT (RXT_BIT)
    ) u_core (
        .clk          (clk),
        .rst          (rst),
        .ext_cause    (cause_pulse),
        .ext_now      (cause_now),
        .int_cause    (int_cause),
        .icr_rd       (icr_rd),
        .mask_wr      (mask_wr),
        .mask_wdata   (wr_data[CAUSE_W-1:0]),
        .thr_zero     (thr_val == '0),
        .thr_expire   (thr_exp),
        .rxpkt_busy   (dly_busy[TMR_RX_PKT]),
        .start_thr    (thr_start),
        .cancel_thr   (thr_cancel),
        .cancel_rxpkt (cancel_rxpkt),
        .add_vec      (core_add),
        .mask_q       (core_mask),
        .cause_q      (cause_q),
        .irq_o        (irq_o)
    );

endmodule

// File: rtl/irq_throttle_chk.sv
module irq_throttle_chk
    import irq_pkg::*;
#(
    parameter int CAUSE_W = 8,
    parameter int VAL_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_o,
    input logic [CAUSE_W:0]   cause_q,
    input logic               icr_rd,
    input logic               wr_en,
    input logic [2:0]         wr_sel,
    input logic [VAL_W-1:0]   wr_data,
    input logic [CAUSE_W-1:0] cause_pulse,
    input logic               cause_now,
    input logic               rx_pkt_done,
    input logic               tx_pkt_done,
    input logic [CAUSE_W-1:0] add_vec,
    input logic [CAUSE_W-1:0] mask_q,
    input logic               thr_busy,
    input logic [3:0]         dly_busy
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (cause_q == '0) && !irq_o); // R1

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !icr_rd |=> ((cause_q[CAUSE_W-1:0] & $past(cause_q[CAUSE_W-1:0]))
                     == $past(cause_q[CAUSE_W-1:0]))); // R2

    AST_URGENT_POSTS: assert property (@(posedge clk) disable iff (rst)
        (cause_now && (|(cause_pulse & mask_q)) && !(wr_en && wr_sel == SEL_MASK))
        |=> irq_o); // R5

    AST_THR_IDLE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> !thr_busy); // R5

    AST_RISE_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> (|(cause_q[CAUSE_W-1:0] & mask_q))); // R7

    AST_MASK_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_MASK &&
         (((cause_q[CAUSE_W-1:0] | add_vec) & wr_data[CAUSE_W-1:0]) == '0))
        |=> !irq_o); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (icr_rd && add_vec == '0) |=> (cause_q == '0)); // R9

    AST_RX_TMR_SOURCE: assert property (@(posedge clk) disable iff (rst)
        ($rose(dly_busy[0]) || $rose(dly_busy[1])) |-> $past(rx_pkt_done)); // R12

    AST_TX_TMR_SOURCE: assert property (@(posedge clk) disable iff (rst)
        ($rose(dly_busy[2]) || $rose(dly_busy[3])) |-> $past(tx_pkt_done)); // R11

endmodule

bind irq_throttle_ctrl irq_throttle_chk #(
    .CAUSE_W (CAUSE_W),
    .VAL_W   (VAL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_o       (irq_o),
    .cause_q     (cause_q),
    .icr_rd      (icr_rd),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .cause_pulse (cause_pulse),
    .cause_now   (cause_now),
    .rx_pkt_done (rx_pkt_done),
    .tx_pkt_done (tx_pkt_done),
    .add_vec     (core_add),
    .mask_q      (core_mask),
    .thr_busy    (thr_busy),
    .dly_busy    (dly_busy)
);

// File: tb/test_irq_throttle_ctrl.sv
module test_irq_throttle_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cause_pulse = '0;
    logic       cause_now = 1'b0;
    logic       rx_pkt_done = 1'b0;
    logic       tx_pkt_done = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic       icr_rd = 1'b0;
    logic       irq_o;
    logic [8:0] cause_q;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int         at;
        logic       irq;
        logic [8:0] cause;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_throttle_ctrl i_irq_throttle_ctrl (
        .clk(clk), .rst(rst), .cause_pulse(cause_pulse), .cause_now(cause_now),
        .rx_pkt_done(rx_pkt_done), .tx_pkt_done(tx_pkt_done), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .icr_rd(icr_rd),
        .irq_o(irq_o), .cause_q(cause_q)
    );

    // Monitor: compare scoreboard items due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                n_run++;
                if (irq_o !== sb[i].irq || cause_q !== sb[i].cause) begin
                    n_fail++;
                    $display("FAIL %s cyc %0d: irq=%0b cause=%03h, expected irq=%0b cause=%03h",
                             sb[i].req, cyc, irq_o, cause_q, sb[i].irq, sb[i].cause);
                end
                sb.delete(i);
            end
        end
    end

    task automatic expect_at(input int at, input logic irq, input logic [8:0] cv, input string r);
        exp_t e;
        e.at = at; e.irq = irq; e.cause = cv; e.req = r;
        sb.push_back(e);
    endtask

    task automatic idle_to(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] b, input logic now, output int t);
        cause_pulse = b; cause_now = now; t = cyc;
        @(negedge clk);
        cause_pulse = '0; cause_now = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d, output int t);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; t = cyc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(output int t);
        icr_rd = 1'b1; t = cyc;
        @(negedge clk);
        icr_rd = 1'b0;
    endtask

    task automatic rxd(output int t);
        rx_pkt_done = 1'b1; t = cyc;
        @(negedge clk);
        rx_pkt_done = 1'b0;
    endtask

    task automatic txd(output int t);
        tx_pkt_done = 1'b1; t = cyc;
        @(negedge clk);
        tx_pkt_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int t0, t1, t2, t3, t;
        @(negedge clk);
        expect_at(cyc + 1, 1'b0, 9'h000, "R1");
        idle_to(3);
        rst = 1'b0;
        expect_at(cyc + 1, 1'b0, 9'h000, "R1");

        // R3 / R2: zero throttle posts at once
        wr(3'd0, 16'h00FF, t);
        pulse(8'h04, 1'b0, t0);
        expect_at(t0 + 1, 1'b1, 9'h104, "R3");
        idle_to(1);
        rd(t);
        expect_at(t + 1, 1'b0, 9'h000, "R9");
        idle_to(1);

        // R7 / R8: masked cause, then mask write posts
        wr(3'd0, 16'h00F7, t);
        pulse(8'h08, 1'b0, t0);
        expect_at(t0 + 1, 1'b0, 9'h008, "R7");
        idle_to(1);
        wr(3'd0, 16'h00FF, t1);
        expect_at(t1 + 1, 1'b1, 9'h108, "R8");
        idle_to(1);
        rd(t);
        idle_to(1);

        // R4: throttle interval 3 (12 cycles), no restart by a later cause
        wr(3'd1, 16'd3, t);
        pulse(8'h02, 1'b0, t0);
        idle_to(2);
        pulse(8'h10, 1'b0, t1);
        expect_at(t0 + 12, 1'b0, 9'h012, "R4");
        expect_at(t0 + 13, 1'b1, 9'h112, "R4");
        idle_to(12);
        rd(t);
        expect_at(t + 1, 1'b0, 9'h000, "R9");
        idle_to(1);

        // R4: rewriting interval leaves the running timer alone
        pulse(8'h02, 1'b0, t0);
        wr(3'd1, 16'd10, t);
        expect_at(t0 + 12, 1'b0, 9'h002, "R4");
        expect_at(t0 + 13, 1'b1, 9'h102, "R4");
        idle_to(13);
        rd(t);
        pulse(8'h02, 1'b0, t1);
        expect_at(t1 + 40, 1'b0, 9'h002, "R4");
        expect_at(t1 + 41, 1'b1, 9'h102, "R4");
        idle_to(42);
        rd(t);
        wr(3'd1, 16'd3, t);

        // R5: urgent bypass and throttle cancel
        pulse(8'h02, 1'b0, t0);
        idle_to(1);
        pulse(8'h20, 1'b1, t1);
        expect_at(t1 + 1, 1'b1, 9'h122, "R5");
        rd(t2);
        expect_at(t2 + 1, 1'b0, 9'h000, "R9");
        pulse(8'h40, 1'b0, t3);
        expect_at(t3 + 9, 1'b0, 9'h040, "R5");
        expect_at(t3 + 12, 1'b0, 9'h040, "R4");
        expect_at(t3 + 13, 1'b1, 9'h140, "R4");
        idle_to(14);
        rd(t);
        idle_to(1);

        // R6 / R8: duplicate cause must not arm the throttle
        wr(3'd1, 16'd2, t);
        pulse(8'h02, 1'b0, t0);
        expect_at(t0 + 9, 1'b1, 9'h102, "R4");
        idle_to(9);
        wr(3'd0, 16'h0000, t1);
        expect_at(t1 + 1, 1'b0, 9'h002, "R8");
        pulse(8'h02, 1'b0, t2);
        idle_to(3);
        wr(3'd0, 16'h00FF, t3);
        expect_at(t3 + 5, 1'b0, 9'h002, "R6");
        expect_at(t3 + 8, 1'b0, 9'h002, "R8");
        expect_at(t3 + 9, 1'b1, 9'h102, "R8");
        idle_to(10);
        rd(t);
        wr(3'd1, 16'd0, t);

        // R10: receive per-packet timer folded into a post
        wr(3'd2, 16'd5, t);
        rxd(t0);
        idle_to(2);
        pulse(8'h04, 1'b1, t1);
        expect_at(t1 + 1, 1'b1, 9'h184, "R10");
        rd(t2);
        expect_at(t2 + 1, 1'b0, 9'h000, "R9");
        expect_at(t0 + 11, 1'b0, 9'h000, "R10");
        expect_at(t0 + 12, 1'b0, 9'h000, "R10");
        idle_to(12);

        // R11: per-packet timer restarts on every packet
        rxd(t0);
        idle_to(2);
        rxd(t1);
        expect_at(t0 + 11, 1'b0, 9'h000, "R11");
        expect_at(t1 + 10, 1'b0, 9'h000, "R11");
        expect_at(t1 + 11, 1'b1, 9'h180, "R11");
        idle_to(12);
        rd(t);
        idle_to(1);

        // R12: absolute timer caps the wait and is not restarted
        wr(3'd3, 16'd3, t);
        rxd(t0);
        idle_to(1);
        rxd(t1);
        idle_to(1);
        rxd(t2);
        expect_at(t0 + 6, 1'b0, 9'h000, "R12");
        expect_at(t0 + 7, 1'b1, 9'h180, "R12");
        idle_to(3);
        rd(t3);
        expect_at(t3 + 1, 1'b0, 9'h000, "R9");
        expect_at(t0 + 16, 1'b0, 9'h000, "R10");
        idle_to(10);
        wr(3'd3, 16'd0, t);
        wr(3'd2, 16'd0, t);

        // R11 / R12: zero transmit delay posts at once, absolute not armed
        wr(3'd5, 16'd4, t);
        txd(t0);
        expect_at(t0 + 1, 1'b1, 9'h101, "R11");
        rd(t1);
        expect_at(t1 + 1, 1'b0, 9'h000, "R9");
        expect_at(t0 + 9, 1'b0, 9'h000, "R12");
        expect_at(t0 + 10, 1'b0, 9'h000, "R12");
        idle_to(10);

        // R11: transmit per-packet expiry
        wr(3'd5, 16'd0, t);
        wr(3'd4, 16'd2, t);
        txd(t0);
        expect_at(t0 + 4, 1'b0, 9'h000, "R11");
        expect_at(t0 + 5, 1'b1, 9'h101, "R11");
        idle_to(6);
        rd(t);
        expect_at(t + 1, 1'b0, 9'h000, "R9");
        idle_to(3);

        foreach (sb[i]) begin
            n_run++; n_fail++;
            $display("FAIL %s: check at cyc %0d never evaluated, expected cause=%03h",
                     sb[i].req, sb[i].at, sb[i].cause);
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule